// File: doc/BRIEF.md
# Multi-bank glitch-free clock divider

This block turns one fast source clock, which stands in for an oscillator output, into four slower clocks: three output banks (A, B and C) and a feedback clock. All four are square waves whose period is an even number of source cycles. A prescale select chooses between a base and a doubled set of ratios. Each bank then has its own one-bit ratio select, and the feedback clock has a two-bit select. Every output is the output of a flip-flop clocked by the source clock. The block has no other clock domain.

The selects may be changed at any time while the clocks run. Each output keeps its current ratio until it reaches the end of a low phase. The new ratio then starts with a full high phase, so no output ever produces a runt or stretched cycle. The output enable stops the three banks at a steady low level and leaves the feedback clock running. The active-low master reset clears every divider and marks all four outputs as not driven, using one valid flag per output. When reset is released, the dividers restart from a known phase.

Top module: `multi_bank_clkdiv`

## Requirements
- R1: Bank A and bank B each produce a period of 4 source cycles when their select is 0 and 8 when it is 1, with prescale select 0. Both values double to 8 and 16 with prescale select 1.
- R2: Bank C produces a period of 8 source cycles when its select is 0 and 12 when it is 1, with prescale select 0. The values become 16 and 24 with prescale select 1.
- R3: The feedback period is set by the code {pre_sel, fb_sel[1], fb_sel[0]}. Codes 000, 001, 010 and 011 give 8, 12, 16 and 24 source cycles. Codes 100, 101, 110 and 111 give 16, 24, 32 and 48.
- R4: In steady state, each output's high phase and low phase each last exactly half of its period. While an output toggles, no phase is shorter than 2 or longer than 24 source cycles.
- R5: After any change of the selects, every period an output produces lies between the old and the new period, inclusive. The old ratio runs until the end of a low phase, and the new ratio begins there with a full high phase. The selects pass through a two-stage synchroniser first.
- R6: While output enable is low (after synchronisation), clk_a, clk_b and clk_c stay low. clk_fb keeps toggling at its selected period.
- R7: One cycle after mreset_n is sampled low, all four clocks are low and out_valid is 0. out_valid bit 0 belongs to bank A, bit 1 to bank B, bit 2 to bank C and bit 3 to the feedback clock. On the first cycle after release, out_valid is all ones. Each output's first rising edge follows after half its period counted in source cycles.
- R8: Output enable changes take effect only at the end of a low phase of the affected bank. A high pulse in progress always completes at full length. After re-enable, the banks resume at their selected periods with full-length pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock; all state runs on its rising edge |
| mreset_n | input | 1 | Active-low master reset, sampled on clk_src |
| oe | input | 1 | Output enable for banks A, B and C; synchronised internally |
| pre_sel | input | 1 | Prescale select: 0 base ratios, 1 doubled ratios |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| fb_sel | input | 2 | Feedback ratio select, bit 1 and bit 0 of the code |
| clk_a | output | 1 | Bank A divided clock |
| clk_b | output | 1 | Bank B divided clock |
| clk_c | output | 1 | Bank C divided clock |
| clk_fb | output | 1 | Feedback divided clock, not gated by oe |
| out_valid | output | 4 | Per-output driven flag: bit 0 A, 1 B, 2 C, 3 feedback |

## Verification
The divider is first swept through all sixteen combinations of the prescale select and the three bank selects, with the feedback code stepped along in a pattern that covers all eight feedback codes. Measuring the period and high time of every output after each step separates the prescaler doubling from the per-bank ratio choice, and shows that bank C decodes differently from banks A and B. A run of random select changes, spaced so that only one change is in flight at a time, measures every period across the switch. This separates a boundary-aligned update from one that cuts a phase short or holds it too long. Dropping and raising output enable with slow ratios shows that only the banks stop, each on a full pulse. Resetting with the fastest and the slowest feedback ratio pins down the restart phase.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    // Width of the half-period counters; the longest half period is 24.
    localparam int HALF_W   = 5;
    localparam int MIN_HALF = 2;
    localparam int MAX_HALF = 24;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Control inputs as they travel through the synchroniser.
    typedef struct packed {
        logic       pre;
        logic       sa;
        logic       sb;
        logic       sc;
        logic [1:0] fb;
        logic       oe;
    } ctl_t;

    // Half period of banks A and B in source cycles.
    function automatic half_t half_ab(input logic pre, input logic sel);
        half_t base;
        base = sel ? half_t'(4) : half_t'(2);
        return pre ? half_t'(base << 1) : base;
    endfunction

    // Half period of bank C in source cycles.
    function automatic half_t half_c(input logic pre, input logic sel);
        half_t base;
        base = sel ? half_t'(6) : half_t'(4);
        return pre ? half_t'(base << 1) : base;
    endfunction

    // Half period of the feedback output in source cycles.
    function automatic half_t half_fb(input logic pre, input logic [1:0] code);
        half_t base;
        case (code)
            2'd0:    base = half_t'(4);
            2'd1:    base = half_t'(6);
            2'd2:    base = half_t'(8);
            default: base = half_t'(12);
        endcase
        return pre ? half_t'(base << 1) : base;
    endfunction

endpackage

// File: rtl/mbc_sync.sv
module mbc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Plain flop chain; all bits advance on the same edge.
    always_ff @(posedge clk) begin
        pipe[0] <= d;
        for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/mbc_div_lane.sv
module mbc_div_lane
    import mbc_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] half_i,
    input  logic          en_i,
    output logic          clk_o,
    output logic          valid_o
);

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] half_q;
    phase_e        ph_q;
    logic          lvl_q;
    logic          vld_q;
    logic          expire;

    assign expire = (cnt_q == '0);

    // The half period and the enable are taken in only where a low
    // phase ends, so the following high phase is always whole.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= half_i - HW'(1);
            half_q <= half_i;
            ph_q   <= PH_LOW;
            lvl_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b1;
            if (expire) begin
                if (ph_q == PH_LOW) begin
                    ph_q   <= PH_HIGH;
                    half_q <= half_i;
                    cnt_q  <= half_i - HW'(1);
                    lvl_q  <= en_i;
                end else begin
                    ph_q   <= PH_LOW;
                    cnt_q  <= half_q - HW'(1);
                    lvl_q  <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - HW'(1);
            end
        end
    end

    assign clk_o   = lvl_q;
    assign valid_o = vld_q;

endmodule

// File: rtl/multi_bank_clkdiv.sv
module multi_bank_clkdiv
    import mbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_src,
    input  logic       mreset_n,
    input  logic       oe,
    input  logic       pre_sel,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       sel_c,
    input  logic [1:0] fb_sel,
    output logic       clk_a,
    output logic       clk_b,
    output logic       clk_c,
    output logic       clk_fb,
    output logic [3:0] out_valid
);

    localparam int NBANK = 3;
    localparam int CTL_W = $bits(ctl_t);

    logic rst;
    ctl_t ctl_raw;
    ctl_t ctl_s;

    assign rst = ~mreset_n;

    assign ctl_raw = '{pre: pre_sel, sa: sel_a, sb: sel_b, sc: sel_c,
                       fb: fb_sel, oe: oe};

    mbc_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk_src),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    logic [NBANK-1:0] bank_sel;
    logic [NBANK-1:0] bank_clk;
    logic [NBANK-1:0] bank_vld;
    half_t            bank_half [NBANK];
    half_t            fb_half;
    logic             fb_clk;
    logic             fb_vld;

    assign bank_sel = {ctl_s.sc, ctl_s.sb, ctl_s.sa};
    assign fb_half  = half_fb(ctl_s.pre, ctl_s.fb);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        if (g == NBANK - 1) begin : g_dec_c
            assign bank_half[g] = half_c(ctl_s.pre, bank_sel[g]);
        end else begin : g_dec_ab
            assign bank_half[g] = half_ab(ctl_s.pre, bank_sel[g]);
        end

        mbc_div_lane #(
            .HW (HALF_W)
        ) u_lane (
            .clk     (clk_src),
            .rst     (rst),
            .half_i  (bank_half[g]),
            .en_i    (ctl_s.oe),
            .clk_o   (bank_clk[g]),
            .valid_o (bank_vld[g])
        );
    end

    mbc_div_lane #(
        .HW (HALF_W)
    ) u_fb_lane (
        .clk     (clk_src),
        .rst     (rst),
        .half_i  (fb_half),
        .en_i    (1'b1),
        .clk_o   (fb_clk),
        .valid_o (fb_vld)
    );

    assign clk_a     = bank_clk[0];
    assign clk_b     = bank_clk[1];
    assign clk_c     = bank_clk[2];
    assign clk_fb    = fb_clk;
    assign out_valid = {fb_vld, bank_vld};

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker
    import mbc_pkg::*;
(
    input logic       clk_src,
    input logic       mreset_n,
    input logic       oe,
    input logic       clk_a,
    input logic       clk_b,
    input logic       clk_c,
    input logic       clk_fb,
    input logic [3:0] out_valid
);

    localparam int RUN_W = 6;

    logic [3:0]       lv;
    logic [3:0]       lv_q;
    logic [RUN_W-1:0] run_q [4];

    assign lv = {clk_fb, clk_c, clk_b, clk_a};

    // run_q holds the length of the level that is ending when lv differs from lv_q.
    always_ff @(posedge clk_src) begin
        if (!mreset_n) begin
            lv_q <= '0;
            for (int i = 0; i < 4; i++) run_q[i] <= '0;
        end else begin
            lv_q <= lv;
            for (int i = 0; i < 4; i++) begin
                if (lv[i] != lv_q[i])      run_q[i] <= RUN_W'(1);
                else if (run_q[i] != '1)   run_q[i] <= run_q[i] + RUN_W'(1);
            end
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_out
        a_r5_no_runt: assert property (@(posedge clk_src) disable iff (!mreset_n)
            (lv[i] != lv_q[i]) |-> (run_q[i] >= RUN_W'(MIN_HALF)));

        a_r4_high_bound: assert property (@(posedge clk_src) disable iff (!mreset_n)
            (lv_q[i] && !lv[i]) |-> (run_q[i] <= RUN_W'(MAX_HALF)));
    end

    for (genvar i = 0; i < 3; i++) begin : g_bank
        a_r6_oe_gate: assert property (@(posedge clk_src) disable iff (!mreset_n)
            (!oe && !$past(oe) && !$past(oe, 2) && !$past(oe, 3))
            |-> !(lv[i] && !lv_q[i]));
    end

    a_r6_fb_free: assert property (@(posedge clk_src) disable iff (!mreset_n)
        run_q[3] <= RUN_W'(MAX_HALF));

    a_r7_reset_quiet: assert property (@(posedge clk_src)
        !mreset_n |=> (out_valid == 4'h0 && lv == 4'h0));

    a_r7_valid_up: assert property (@(posedge clk_src) disable iff (!mreset_n)
        mreset_n |=> (out_valid == 4'hf));

endmodule

bind multi_bank_clkdiv mbc_checker u_chk (
    .clk_src   (clk_src),
    .mreset_n  (mreset_n),
    .oe        (oe),
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .clk_c     (clk_c),
    .clk_fb    (clk_fb),
    .out_valid (out_valid)
);

// File: tb/test_multi_bank_clkdiv.sv
module test_multi_bank_clkdiv;

    logic       clk = 1'b0;
    logic       mreset_n = 1'b0;
    logic       oe = 1'b1;
    logic       pre_sel = 1'b0;
    logic       sel_a = 1'b0;
    logic       sel_b = 1'b0;
    logic       sel_c = 1'b0;
    logic [1:0] fb_sel = 2'd0;
    logic       clk_a, clk_b, clk_c, clk_fb;
    logic [3:0] out_valid;
    logic [3:0] outs;

    multi_bank_clkdiv i_multi_bank_clkdiv (
        .clk_src   (clk),
        .mreset_n  (mreset_n),
        .oe        (oe),
        .pre_sel   (pre_sel),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c     (sel_c),
        .fb_sel    (fb_sel),
        .clk_a     (clk_a),
        .clk_b     (clk_b),
        .clk_c     (clk_c),
        .clk_fb    (clk_fb),
        .out_valid (out_valid)
    );

    always #5 clk = ~clk;

    assign outs = {clk_fb, clk_c, clk_b, clk_a};

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    cyc = 0;
    int    lr [4] = '{-1, -1, -1, -1};
    int    rt [4] = '{-1, -1, -1, -1};
    int    lp [4] = '{0, 0, 0, 0};
    int    lh [4] = '{0, 0, 0, 0};
    int    lo [4] = '{4, 4, 8, 8};
    int    hi [4] = '{4, 4, 8, 8};
    int    cur [4] = '{4, 4, 8, 8};
    bit    fresh [4] = '{1'b1, 1'b1, 1'b1, 1'b1};
    logic [3:0] prv = 4'h0;
    string rtag [4] = '{"R1", "R1", "R2", "R3"};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected periods in source cycles, straight from the ratio tables.
    function automatic int exp_ratio(input int idx, input bit p, input bit a,
                                     input bit b, input bit c, input bit [1:0] f);
        int base;
        case (idx)
            0: base = a ? 8 : 4;
            1: base = b ? 8 : 4;
            2: base = c ? 12 : 8;
            default: begin
                case (f)
                    2'd0: base = 8;
                    2'd1: base = 12;
                    2'd2: base = 16;
                    default: base = 24;
                endcase
            end
        endcase
        return p ? base * 2 : base;
    endfunction

    // Period and high-time monitor; every period is held to the allowed range (R5),
    // every high phase to half of a period in that range (R4).
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 4; i++) begin
            if (!mreset_n) begin
                lr[i] = -1;
                rt[i] = -1;
            end else if (outs[i] && !prv[i]) begin
                if (!fresh[i] && lr[i] >= 0) begin
                    lp[i] = cyc - lr[i];
                    check(lp[i] >= lo[i] && lp[i] <= hi[i], "R5",
                          $sformatf("out%0d period in %0d..%0d", i, lo[i], hi[i]),
                          lp[i], lo[i]);
                end
                fresh[i] = 1'b0;
                lr[i] = cyc;
                rt[i] = cyc;
            end else if (!outs[i] && prv[i] && rt[i] >= 0) begin
                lh[i] = cyc - rt[i];
                check(lh[i] * 2 >= lo[i] && lh[i] * 2 <= hi[i], "R4",
                      $sformatf("out%0d high time x2 in %0d..%0d", i, lo[i], hi[i]),
                      lh[i] * 2, lo[i]);
            end
        end
        prv = outs;
    end

    task automatic set_cfg(input bit p, input bit a, input bit b, input bit c,
                           input bit [1:0] f);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            int e;
            e = exp_ratio(i, p, a, b, c, f);
            lo[i]  = (e < cur[i]) ? e : cur[i];
            hi[i]  = (e > cur[i]) ? e : cur[i];
            cur[i] = e;
        end
        pre_sel = p;
        sel_a   = a;
        sel_b   = b;
        sel_c   = c;
        fb_sel  = f;
    endtask

    task automatic test_reset(input bit p, input bit [1:0] f);
        int n;
        @(negedge clk);
        mreset_n = 1'b0;
        set_cfg(p, 1'b0, 1'b0, 1'b0, f);
        repeat (5) @(negedge clk);
        check(out_valid == 4'h0, "R7", "out_valid in reset", out_valid, 0);
        check(outs == 4'h0, "R7", "clocks in reset", outs, 0);
        for (int i = 0; i < 4; i++) begin
            lo[i] = cur[i];
            hi[i] = cur[i];
            fresh[i] = 1'b1;
        end
        mreset_n = 1'b1;
        n = 0;
        while (n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1)
                check(out_valid == 4'hf, "R7", "out_valid after release", out_valid, 15);
            if (clk_fb) break;
        end
        check(n == cur[3] / 2, "R7", "cycles to first feedback rise", n, cur[3] / 2);
        repeat (150) @(negedge clk);
        check(lp[3] == cur[3], "R3", "feedback period after reset", lp[3], cur[3]);
    endtask

    task automatic test_sweep();
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                bit [2:0] sv;
                sv = 3'(s);
                set_cfg(p[0], sv[0], sv[1], sv[2], sv[1:0]);
                repeat (200) @(negedge clk);
                for (int i = 0; i < 4; i++) begin
                    check(lp[i] == cur[i], rtag[i],
                          $sformatf("out%0d period pre=%0d sel=%0d", i, p, s),
                          lp[i], cur[i]);
                    check(lh[i] * 2 == cur[i], "R4",
                          $sformatf("out%0d high time x2 pre=%0d sel=%0d", i, p, s),
                          lh[i] * 2, cur[i]);
                end
            end
        end
    endtask

    task automatic test_random();
        for (int k = 0; k < 24; k++) begin
            int unsigned r;
            r = $urandom;
            set_cfg(r[0], r[1], r[2], r[3], r[5:4]);
            repeat (110 + ($urandom % 50)) @(negedge clk);
        end
        repeat (200) @(negedge clk);
        for (int i = 0; i < 4; i++)
            check(lp[i] == cur[i], "R5", $sformatf("out%0d period after random run", i),
                  lp[i], cur[i]);
    endtask

    task automatic test_oe();
        bit seen_high;
        set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 2'd3);
        repeat (200) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            lo[i] = cur[i];
            hi[i] = cur[i];
        end
        oe = 1'b0;
        repeat (100) @(negedge clk);
        for (int i = 0; i < 3; i++)
            check(lh[i] * 2 == cur[i], "R8", $sformatf("bank%0d last pulse x2", i),
                  lh[i] * 2, cur[i]);
        seen_high = 1'b0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (clk_a || clk_b || clk_c) seen_high = 1'b1;
        end
        check(!seen_high, "R6", "banks high while disabled", seen_high, 0);
        check(lp[3] == cur[3], "R6", "feedback period while disabled", lp[3], cur[3]);
        check(cyc - lr[3] <= cur[3], "R6", "cycles since feedback rise",
              cyc - lr[3], cur[3]);
        for (int i = 0; i < 3; i++) fresh[i] = 1'b1;
        oe = 1'b1;
        repeat (200) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(lp[i] == cur[i], "R8", $sformatf("bank%0d period after re-enable", i),
                  lp[i], cur[i]);
            check(lh[i] * 2 == cur[i], "R8", $sformatf("bank%0d pulse x2 after re-enable", i),
                  lh[i] * 2, cur[i]);
        end
    endtask

    initial begin
        test_reset(1'b0, 2'd0);
        test_sweep();
        test_random();
        test_oe();
        test_reset(1'b1, 2'd3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule